// File: doc/BRIEF.md
# Armed Two-Edge Period Meter

This block measures one period of a slow digital signal against a free-running reference count. A single-cycle pulse on the arm input starts a measurement. The first qualified rising edge of the signal after that stores the reference count. The next qualified rising edge computes the elapsed count. The block then stops capturing and raises a done flag. Later edges change nothing until the block is armed again, so the result stays readable for as long as needed.

The signal input is first synchronised to the clock. It then passes through a debouncing filter that looks at the input only once every `DIV` clocks. A new level is accepted only after `FILT_LEN` of those samples in a row agree. Short glitches therefore never count as edges. Both edges of a measurement pass through the same fixed pipeline, so that delay cancels out of the result. The elapsed count is formed modulo 2^`CNT_W`, which keeps the result correct when the reference count wraps between the two edges.

Top module: `period_snap`

## Requirements
- R1: While reset is asserted, and right after it is released, `done_o` is 0 and `period_o` is 0.
- R2: Rising edges on `sig_i` that arrive before the first arm pulse are not captured. A later measurement reports only edges that follow the arm pulse.
- R3: After an arm pulse, `period_o` equals the `count_i` value at the second qualified rising edge minus its value at the first one. `done_o` rises together with this result.
- R4: After only one qualified rising edge following an arm pulse, `done_o` stays 0.
- R5: Once `done_o` is 1, further edges on `sig_i` leave `done_o` at 1 and leave `period_o` unchanged until the next arm pulse.
- R6: When the reference count wraps between the two edges, so that the stop value is below the start value, `period_o` is still the true elapsed count, taken modulo 2^32.
- R7: A level on `sig_i` is accepted only after `FILT_LEN` (3) consecutive samples taken every `DIV` (4) clocks agree. A high pulse of 4 clocks is never treated as an edge.
- R8: Only rising edges are captured. With a 72-clock period, the result is the same whether the high time is short or long.
- R9: An arm pulse clears `done_o` and `period_o` to 0 on the next clock. It also throws away any start value already captured, and this holds in every state. An edge that arrives in the same cycle as the arm pulse is dropped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| arm_i | input | 1 | Single-cycle pulse that starts a new measurement |
| sig_i | input | 1 | Signal whose period is measured, asynchronous |
| count_i | input | 32 | Free-running reference count |
| done_o | output | 1 | High once both edges have been captured |
| period_o | output | 32 | Elapsed count between the two edges; 0 until done |

## Verification
The hardest case to reach from the ports is a re-arm in the middle of a measurement, after a start value is already held but before the second edge. The stimulus arms the block, lets one edge be captured, arms again, and then sends two edges at a different spacing. Only a correct discard of the stale start value gives the second spacing. The wrap case is reached by moving the reference count just below its maximum before arming. A glitch is placed at a spacing different from the true period, so accepting it would show up as a wrong result.

// File: rtl/psnap_pkg.sv
package psnap_pkg;

    // Measurement step: not armed, waiting for the first edge,
    // waiting for the second edge, finished.
    typedef enum logic [1:0] {
        ST_OFF    = 2'd0,
        ST_WAIT_A = 2'd1,
        ST_WAIT_B = 2'd2,
        ST_DONE   = 2'd3
    } step_e;

endpackage

// File: rtl/psnap_tick.sv
// Divided sample strobe: one pulse every DIV clocks.
module psnap_tick #(
    parameter int DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick_o
);
    localparam int TW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [TW-1:0] LAST = TW'(DIV - 1);

    logic [TW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign tick_o = (cnt_q == LAST);
endmodule

// File: rtl/psnap_filt.sv
// Synchroniser, agreement filter and rising-edge pulse.
module psnap_filt #(
    parameter int FILT_LEN = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_i,
    input  logic sig_i,
    output logic rise_o
);
    typedef struct packed {
        logic                s1;
        logic                s2;
        logic [FILT_LEN-1:0] hist;
        logic                level;
        logic                rise;
    } filt_t;

    filt_t f_d, f_q;

    always_comb begin
        f_d      = f_q;
        f_d.s1   = sig_i;
        f_d.s2   = f_q.s1;
        f_d.rise = 1'b0;
        if (tick_i) begin
            f_d.hist = {f_q.hist[FILT_LEN-2:0], f_q.s2};
            if (&f_d.hist) begin
                f_d.level = 1'b1;
                f_d.rise  = ~f_q.level;
            end else if (~|f_d.hist) begin
                f_d.level = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) f_q <= '0;
        else        f_q <= f_d;
    end

    assign rise_o = f_q.rise;
endmodule

// File: rtl/psnap_seq.sv
// One-shot step control and elapsed-count computation.
module psnap_seq
    import psnap_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             arm_i,
    input  logic             rise_i,
    input  logic [CNT_W-1:0] count_i,
    output logic             done_o,
    output logic [CNT_W-1:0] period_o
);
    typedef struct packed {
        step_e            step;
        logic [CNT_W-1:0] start;
        logic [CNT_W-1:0] period;
    } seq_t;

    seq_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (arm_i) begin
            // a pending edge in the arm cycle is dropped
            s_d.step   = ST_WAIT_A;
            s_d.period = '0;
        end else if (rise_i) begin
            unique case (s_q.step)
                ST_WAIT_A: begin
                    s_d.start = count_i;
                    s_d.step  = ST_WAIT_B;
                end
                ST_WAIT_B: begin
                    // modulo 2^CNT_W difference covers a wrapped stop value
                    s_d.period = count_i - s_q.start;
                    s_d.step   = ST_DONE;
                end
                default: s_d = s_q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.step   <= ST_OFF;
            s_q.start  <= '0;
            s_q.period <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign done_o   = (s_q.step == ST_DONE);
    assign period_o = s_q.period;
endmodule

// File: rtl/period_snap.sv
module period_snap #(
    parameter int CNT_W    = 32,
    parameter int DIV      = 4,
    parameter int FILT_LEN = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             arm_i,
    input  logic             sig_i,
    input  logic [CNT_W-1:0] count_i,
    output logic             done_o,
    output logic [CNT_W-1:0] period_o
);
    logic tick_w;
    logic edge_w;

    psnap_tick #(.DIV(DIV)) u_tick (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_o (tick_w)
    );

    psnap_filt #(.FILT_LEN(FILT_LEN)) u_filt (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_i (tick_w),
        .sig_i  (sig_i),
        .rise_o (edge_w)
    );

    psnap_seq #(.CNT_W(CNT_W)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .arm_i    (arm_i),
        .rise_i   (edge_w),
        .count_i  (count_i),
        .done_o   (done_o),
        .period_o (period_o)
    );
endmodule

// File: rtl/psnap_chk.sv
module psnap_chk #(
    parameter int CNT_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             arm_i,
    input logic             edge_w,
    input logic             done_o,
    input logic [CNT_W-1:0] period_o
);
    // R3
    done_follows_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_o) |-> $past(edge_w) && !$past(arm_i));

    // R9
    rearm_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        arm_i |=> (!done_o && period_o == '0));

    // R5
    hold_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !arm_i) |=> (done_o && $stable(period_o)));

    // R4
    period_zero_until_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> (period_o == '0));

    // R7
    single_edge_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        edge_w |=> !edge_w);
endmodule

bind period_snap psnap_chk #(.CNT_W(CNT_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .arm_i    (arm_i),
    .edge_w   (edge_w),
    .done_o   (done_o),
    .period_o (period_o)
);

// File: tb/period_snap_tb.sv
`timescale 1ns/1ps
module period_snap_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        arm_i = 1'b0;
    logic        sig_i = 1'b0;
    logic [31:0] cyc = '0;
    logic [31:0] cnt_off = '0;
    logic [31:0] count_w;
    logic        done_o;
    logic [31:0] period_o;

    int checks = 0;
    int errors = 0;

    logic [31:0] exp_q[$];
    string       tag_q[$];
    logic        done_prev = 1'b0;
    logic [31:0] exp_v;
    string       exp_t;

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 32'd1;
    assign count_w = cnt_off + cyc;

    period_snap u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .arm_i    (arm_i),
        .sig_i    (sig_i),
        .count_i  (count_w),
        .done_o   (done_o),
        .period_o (period_o)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic pulse(input int hi, input int lo);
        sig_i = 1'b1;
        repeat (hi) @(negedge clk);
        sig_i = 1'b0;
        repeat (lo) @(negedge clk);
    endtask

    task automatic arm();
        arm_i = 1'b1;
        @(negedge clk);
        arm_i = 1'b0;
        repeat (8) @(negedge clk);
    endtask

    task automatic expect_period(input logic [31:0] p, input string tag);
        exp_q.push_back(p);
        tag_q.push_back(tag);
    endtask

    // scoreboard monitor: compares each new result with the queue head
    always @(negedge clk) begin
        if (rst_n) begin
            if (done_o && !done_prev) begin
                checks++;
                if (exp_q.size() == 0) begin
                    errors++;
                    $display("FAIL R4 unexpected done actual=%0h expected=none", period_o);
                end else begin
                    exp_v = exp_q.pop_front();
                    exp_t = tag_q.pop_front();
                    if (period_o !== exp_v) begin
                        errors++;
                        $display("FAIL %s period actual=%0d expected=%0d", exp_t, period_o, exp_v);
                    end
                end
            end
            done_prev = done_o;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [31:0] held;
        repeat (3) @(negedge clk);
        chk(done_o == 1'b0, "R1 done in reset", {31'd0, done_o}, 32'd0);
        chk(period_o == 32'd0, "R1 period in reset", period_o, 32'd0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(done_o == 1'b0 && period_o == 32'd0, "R1 after release", period_o, 32'd0);

        // R2: edges without arm are ignored
        pulse(16, 48); pulse(16, 48); pulse(16, 48);
        chk(done_o == 1'b0, "R2 unarmed done", {31'd0, done_o}, 32'd0);
        chk(period_o == 32'd0, "R2 unarmed period", period_o, 32'd0);

        // R3 / R4: basic measurement, check after first edge only
        arm();
        expect_period(32'd100, "R3 basic");
        pulse(20, 80);
        chk(done_o == 1'b0, "R4 one edge only", {31'd0, done_o}, 32'd0);
        pulse(20, 80);

        // R5: further edges after done change nothing
        held = period_o;
        pulse(16, 40);
        pulse(16, 40);
        chk(done_o == 1'b1, "R5 done held", {31'd0, done_o}, 32'd1);
        chk(period_o == held, "R5 period held", period_o, held);

        // R8: long high time, rising edges only
        arm();
        expect_period(32'd72, "R8 long high");
        pulse(60, 12);
        pulse(60, 12);
        repeat (20) @(negedge clk);

        // R6: reference count wraps between edges
        cnt_off = 32'hFFFF_FFD0 - cyc;
        arm();
        expect_period(32'd64, "R6 wrap");
        pulse(16, 48);
        pulse(16, 48);
        repeat (20) @(negedge clk);

        // R7: 4-clock glitch placed 56 clocks before a true edge
        arm();
        expect_period(32'd64, "R7 glitch");
        pulse(4, 52);
        pulse(16, 48);
        pulse(16, 48);

        // R9: re-arm clears outputs immediately
        arm_i = 1'b1;
        @(negedge clk);
        arm_i = 1'b0;
        chk(done_o == 1'b0, "R9 done cleared", {31'd0, done_o}, 32'd0);
        chk(period_o == 32'd0, "R9 period cleared", period_o, 32'd0);
        repeat (8) @(negedge clk);

        // R9: re-arm mid-measurement drops the stale start value
        pulse(16, 48);
        arm();
        expect_period(32'd48, "R9 rearm mid");
        pulse(16, 32);
        pulse(16, 32);
        repeat (20) @(negedge clk);

        chk(exp_q.size() == 0, "R3 all results seen", exp_q.size(), 32'd0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule